// File: doc/BRIEF.md
# Fixed-Priority DMA Channel Scheduler

This block decides which channel of a four-channel DMA controller owns the transfer engine. Each channel has a request line. The engine reports through `unit_done` each time it finishes one transfer unit. In dual-address operation, a unit is finished once the staged data has been written to the destination. The scheduler answers with a one-hot grant. The lowest-numbered requesting channel always wins. The grant is re-evaluated only when the engine is idle or at a unit boundary, so the engine never sees a change part-way through a unit.

A higher-priority request that arrives while a lower channel is moving data takes over at the next unit boundary. The lower channel simply loses the grant. Its counters and addresses live in the engine and are never touched, so it picks up where it stopped once no higher channel is requesting.

Each channel's request source is chosen by parameter, and there are three kinds:
- An internal source is latched on a set strobe and stays pending until software clears it.
- An edge-sensitive external source is latched on a rising edge and released when the engine completes a unit for that channel.
- A level-sensitive external source is not latched at all. The line itself is the request, so the source must hold it until it is served.

Top module: `dma_chan_sched`

## Requirements
- R1: While `rst_n` is low, `grant` is all zeros and every held request is discarded.
- R2: When no channel has a live request and `grant` is zero, `grant` stays all zeros.
- R3: When a new grant is chosen, it goes to the lowest-numbered channel with a live request, with bit i of `grant` meaning channel i.
- R4: While `grant` is non-zero and `unit_done` is low, `grant` does not change, even if a higher-priority request arrives.
- R5: At a unit boundary, a pending higher-priority channel takes the grant in the next cycle. The preempted lower channel regains the grant at the first boundary where no higher channel is requesting.
- R6: An internal channel (default kind code 0, channels 0 and 3) latches a request when its `req_in` bit is high for a cycle. The request survives any number of completed units and is dropped only by a cycle with its `req_clr` bit high and its `req_in` bit low.
- R7: An edge channel (kind code 1, channel 1 by default) latches a request on a low-to-high change of its `req_in` bit. The request is released when `unit_done` is high while that channel holds the grant. A line that stays high does not request again.
- R8: A level channel (kind code 2, channel 2 by default) requests exactly while its `req_in` bit is high, with nothing held.
- R9: `req_clr` has no effect on edge or level channels.
- R10: `unit_done` while `grant` is zero has no effect. From idle, a grant appears in the cycle after the request input.
- R11: `grant` is never more than one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NCH | Per-channel request line or set strobe |
| req_clr | input | NCH | Per-channel clear for internal held requests |
| unit_done | input | 1 | Engine finished one transfer unit for the granted channel |
| grant | output | NCH | One-hot active channel, zero when idle |

## Verification
A wrong held bit shows at the ports no later than the next unit boundary. A lost internal or edge request makes its channel disappear from the grant sequence. A bit that is not released makes an edge channel win a second unit it never asked for. A fault in the boundary logic shows within one cycle: the grant either moves while `unit_done` is low, or fails to move on the cycle after it. Because of this, the scoreboard compares the grant on every cycle against a model built from the requirements. The bench drives preemption and resume, all three source kinds, and stray clears and completions.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

   typedef enum logic [1:0] {
      SRC_INTERNAL = 2'd0,
      SRC_EDGE     = 2'd1,
      SRC_LEVEL    = 2'd2
   } src_kind_e;

   function automatic logic [1:0] kind_of(input logic [63:0] kinds, input int idx);
      return kinds[2*idx +: 2];
   endfunction

endpackage

// File: rtl/dma_req_hold.sv
module dma_req_hold
   import dma_sched_pkg::*;
#(
   parameter logic [1:0] KIND = SRC_INTERNAL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line,
   input  logic clr,
   input  logic ack,
   output logic live,
   output logic held
);

   localparam bit USE_CLR = (KIND == SRC_INTERNAL);
   localparam bit USE_ACK = (KIND == SRC_EDGE);
   localparam bit PASS    = (KIND == SRC_LEVEL);

   logic set_ev;
   logic held_q;
   logic held_nxt;
   logic clr_eff;
   logic ack_eff;

   generate
      if (KIND == SRC_EDGE) begin : g_edge
         logic line_q;
         always_ff @(posedge clk) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= line;
         end
         assign set_ev = line & ~line_q;
      end else if (KIND == SRC_INTERNAL) begin : g_int
         assign set_ev = line;
      end else begin : g_level
         assign set_ev = 1'b0;
      end
   endgenerate

   assign clr_eff  = USE_CLR & clr & ~line;
   assign ack_eff  = USE_ACK & ack;
   assign held_nxt = set_ev | (held_q & ~clr_eff & ~ack_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= held_nxt;
   end

   assign live = PASS ? line : held_nxt;
   assign held = held_q;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] pick
);

   always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/dma_grant_ctl.sv
module dma_grant_ctl #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         unit_done,
   input  logic [N-1:0] pick,
   output logic [N-1:0] grant,
   output logic [N-1:0] ack
);

   logic [N-1:0] grant_q;
   logic         boundary;

   assign boundary = (grant_q == '0) | unit_done;

   always_ff @(posedge clk) begin
      if (!rst_n)        grant_q <= '0;
      else if (boundary) grant_q <= pick;
   end

   assign ack   = grant_q & {N{unit_done}};
   assign grant = grant_q;

endmodule

// File: rtl/dma_chan_sched.sv
module dma_chan_sched
   import dma_sched_pkg::*;
#(
   parameter int              NCH     = 4,
   parameter logic [2*NCH-1:0] CH_KIND = 8'b00_10_01_00
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req_in,
   input  logic [NCH-1:0] req_clr,
   input  logic           unit_done,
   output logic [NCH-1:0] grant
);

   localparam int KW = 2 * NCH;

   generate
      if (NCH < 2 || NCH > 32) begin : g_bad_nch
         $error("dma_chan_sched: NCH must lie in 2..32");
      end
   endgenerate

   logic [NCH-1:0] live_req;
   logic [NCH-1:0] held_req;
   logic [NCH-1:0] pick;
   logic [NCH-1:0] ack;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam logic [1:0] K = CH_KIND[2*c +: 2];
         if (K == 2'd3) begin : g_bad_kind
            $error("dma_chan_sched: undefined source kind on a channel");
         end
         dma_req_hold #(.KIND(K)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .line  (req_in[c]),
            .clr   (req_clr[c]),
            .ack   (ack[c]),
            .live  (live_req[c]),
            .held  (held_req[c])
         );
      end
   endgenerate

   dma_prio_pick #(.N(NCH)) u_pick (
      .req  (live_req),
      .pick (pick)
   );

   dma_grant_ctl #(.N(NCH)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .unit_done (unit_done),
      .pick      (pick),
      .grant     (grant),
      .ack       (ack)
   );

   logic [KW-1:0] kind_unused;
   assign kind_unused = CH_KIND;

endmodule

// File: rtl/dma_chan_sched_chk.sv
module dma_chan_sched_chk #(
   parameter int               NCH     = 4,
   parameter logic [2*NCH-1:0] CH_KIND = 8'b00_10_01_00
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] req_in,
   input logic [NCH-1:0] req_clr,
   input logic           unit_done,
   input logic [NCH-1:0] grant,
   input logic [NCH-1:0] live_req,
   input logic [NCH-1:0] held_req
);

   p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && !unit_done) |=> $stable(grant));

   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0 && live_req == '0) |=> grant == '0);

   p_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant == '0 || unit_done) && live_req != '0)
      |=> grant == ($past(live_req) & (~$past(live_req) + 1'b1)));

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ck
         if (CH_KIND[2*c +: 2] == 2'd0) begin : g_int
            p_int_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
               (held_req[c] && !req_clr[c]) |=> held_req[c]);
         end else if (CH_KIND[2*c +: 2] == 2'd1) begin : g_edge
            p_edge_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
               (held_req[c] && unit_done && grant[c] && !req_in[c]) |=> !held_req[c]);
            p_edge_noclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
               (held_req[c] && !(unit_done && grant[c])) |=> held_req[c]);
         end else begin : g_lvl
            p_level_nohold_r8: assert property (@(posedge clk) disable iff (!rst_n)
               !held_req[c]);
         end
      end
   endgenerate

endmodule

bind dma_chan_sched dma_chan_sched_chk #(.NCH(NCH), .CH_KIND(CH_KIND)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_in    (req_in),
   .req_clr   (req_clr),
   .unit_done (unit_done),
   .grant     (grant),
   .live_req  (live_req),
   .held_req  (held_req)
);

// File: tb/dma_chan_sched_bench.sv
module dma_chan_sched_bench;

   localparam int NCH = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] req_in = '0;
   logic [NCH-1:0] req_clr = '0;
   logic           unit_done = 1'b0;
   logic [NCH-1:0] grant;

   int errors = 0;
   int checks = 0;
   bit done_flag = 1'b0;

   always #5 clk = ~clk;

   dma_chan_sched u_dma_chan_sched (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (req_in),
      .req_clr   (req_clr),
      .unit_done (unit_done),
      .grant     (grant)
   );

   // kinds: ch0 internal, ch1 edge, ch2 level, ch3 internal
   logic [NCH-1:0] m_int   = 4'b1001;
   logic [NCH-1:0] m_edge  = 4'b0010;
   logic [NCH-1:0] m_level = 4'b0100;

   logic [NCH-1:0] mh = '0;
   logic [NCH-1:0] mprev = '0;
   logic [NCH-1:0] mg = '0;

   logic [NCH-1:0] exp_q[$];
   string          tag_q[$];

   task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s grant=%b expected=%b", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, predict the grant after the edge
   task automatic step(input logic [NCH-1:0] rq, input logic [NCH-1:0] cl,
                       input logic dn, input string tag);
      logic [NCH-1:0] live;
      logic [NCH-1:0] nxt;
      logic [NCH-1:0] lowest;
      @(negedge clk);
      req_in = rq; req_clr = cl; unit_done = dn;
      for (int i = 0; i < NCH; i++) begin
         logic s, k;
         s = m_int[i] ? rq[i] : (m_edge[i] ? (rq[i] & ~mprev[i]) : 1'b0);
         k = mh[i] & ~(m_int[i] & cl[i] & ~rq[i]) & ~(m_edge[i] & dn & mg[i]);
         nxt[i]  = s | k;
         live[i] = m_level[i] ? rq[i] : nxt[i];
      end
      lowest = '0;
      for (int i = NCH - 1; i >= 0; i--) if (live[i]) lowest = '0 | (1 << i);
      if (mg == '0 || dn) mg = lowest;
      mh = nxt;
      mprev = rq;
      exp_q.push_back(mg);
      tag_q.push_back(tag);
   endtask

   // monitor: compare each cycle after the edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [NCH-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, grant, e);
         checks++;
         if (!$onehot0(grant)) begin
            errors++;
            $display("FAIL R11 grant=%b expected=onehot0", grant);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", grant, '0);
      req_in = 4'b1111;
      @(negedge clk);
      check("R1 reset holds", grant, '0);
      req_in = '0;
      @(negedge clk);
      rst_n = 1'b1;

      step(4'b0000, 4'b0000, 1'b0, "R2 idle");
      step(4'b0000, 4'b0000, 1'b0, "R2 idle");
      step(4'b0000, 4'b0000, 1'b1, "R10 done while idle");
      step(4'b0000, 4'b0000, 1'b0, "R10 stay idle");

      // R3: ch0 and ch3 set together, ch0 wins
      step(4'b1001, 4'b0000, 1'b0, "R3 lowest wins");
      step(4'b0000, 4'b0000, 1'b0, "R4 hold");
      step(4'b0000, 4'b0000, 1'b1, "R6 internal kept after unit");
      step(4'b0000, 4'b0001, 1'b0, "R6 clear ch0");
      step(4'b0000, 4'b0000, 1'b1, "R5 ch3 gets grant");
      // R4/R5: ch0 request while ch3 moving
      step(4'b0001, 4'b0000, 1'b0, "R4 no preempt mid unit");
      step(4'b0000, 4'b0000, 1'b0, "R4 no preempt mid unit");
      step(4'b0000, 4'b0000, 1'b1, "R5 preempt to ch0");
      step(4'b0000, 4'b0001, 1'b1, "R5 ch3 resumes");
      step(4'b0000, 4'b0000, 1'b1, "R6 ch3 still held");
      step(4'b0000, 4'b1000, 1'b1, "R6 cleared ch3 leaves");
      step(4'b0000, 4'b0000, 1'b0, "R2 idle again");

      // R7: edge channel, line stays high across units
      step(4'b0010, 4'b0000, 1'b0, "R7 edge latched");
      step(4'b0010, 4'b0000, 1'b0, "R7 hold");
      step(4'b0010, 4'b0000, 1'b1, "R7 released by unit");
      step(4'b0010, 4'b0000, 1'b1, "R7 steady high no rerequest");
      step(4'b0000, 4'b0000, 1'b0, "R7 idle");

      // R9: edge request pending under ch0, clear pulses ignored
      step(4'b0001, 4'b0000, 1'b0, "R3 ch0 grant");
      step(4'b0010, 4'b0000, 1'b0, "R9 ch1 pend");
      step(4'b0000, 4'b0010, 1'b0, "R9 clr on edge ch");
      step(4'b0000, 4'b0011, 1'b1, "R9 ch1 still pending");
      step(4'b0000, 4'b0000, 1'b1, "R7 ch1 released");

      // R8: level channel
      step(4'b0100, 4'b0100, 1'b0, "R8 level grant");
      step(4'b0100, 4'b0000, 1'b1, "R8 level regrant");
      step(4'b0000, 4'b0000, 1'b1, "R8 level gone");
      step(4'b0100, 4'b0000, 1'b0, "R8 level again");
      step(4'b0000, 4'b0000, 1'b0, "R4 hold while line dropped");
      step(4'b0000, 4'b0000, 1'b1, "R8 no memory");
      step(4'b0000, 4'b0000, 1'b0, "R2 final idle");

      repeat (3) @(negedge clk);
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule